// File: doc/BRIEF.md
# Thermal Warning Gain Limiter

This block watches an active-low over-temperature warning from a power output stage. It decides when a protective gain cut is requested from the audio path. A warning must stay present for a long qualification window before anything happens. The window is counted in millisecond ticks that the chip's timebase supplies. Once the window expires, the block raises an "attenuation active" flag and presents a programmable attenuation amount. A downstream gain stage applies that amount. The block does no multiplication itself.

Two configuration inputs control the behaviour. `adj_bypass` turns the feature off completely. `rec_bypass` selects what happens when the warning goes away. With automatic recovery, the cut is dropped as soon as the warning clears. With latching, the cut is kept until software clears `rec_bypass` or the block is reset. Both configuration inputs come out of reset at 1, which is the register-side default. The attenuation amount `post_scale` is an unsigned magnitude in 0.5 dB steps, so the default setting of 6 gives -3 dB.

The controller is a four-state machine:
- `ST_IDLE`: no warning being counted.
- `ST_QUALIFY`: the warning is present and the timer is running.
- `ST_ATTEN`: the cut is applied while the warning persists.
- `ST_HOLD`: the cut is latched after the warning has cleared.

Its transitions are:
- IDLE→QUALIFY: the warning appears while the feature is enabled.
- QUALIFY→IDLE: the warning clears early, or the bypass is set.
- QUALIFY→ATTEN: the timer expires.
- ATTEN→IDLE: the warning clears with auto-recovery, or the bypass is set.
- ATTEN→HOLD: the warning clears while latching.
- HOLD→ATTEN: the warning returns.
- HOLD→IDLE: `rec_bypass` is cleared, or the bypass is set.

Top module: `thermal_gain_limiter`

## Requirements
- R1: `warn_n` is active low (0 = warning present) and passes through two synchroniser flops before the controller sees it. With `ms_tick` high every cycle and QUAL_MS=400, a fall of `warn_n` just before edge 1 makes `atten_active` rise after edge 405 and not earlier.
- R2: Attenuation is applied only after the synchronised warning has been continuously present for more than QUAL_MS millisecond ticks, counted while qualifying (QUAL_MS+1 ticks).
- R3: If the warning goes away before the qualification expires, the count restarts from zero on the next warning.
- R4: While `adj_bypass` is 1, no attenuation is applied. Setting it to 1 while the cut is active removes the cut after the next clock edge.
- R5: With `adj_bypass`=0 and `rec_bypass`=0, an active cut is removed when the warning clears. `atten_active` falls after the third clock edge following the rise of `warn_n`.
- R6: With `adj_bypass`=0 and `rec_bypass`=1, an active cut stays applied after the warning clears.
- R7: A latched cut is released by the first clock edge at which `rec_bypass` is 0.
- R8: `atten_level` equals `post_scale` while `atten_active` is 1, and equals 0 otherwise.
- R9: Reset (`rst_n`=0) clears the cut and the latch. Both outputs read 0 during reset and after it.
- R10: Qualification advances only on cycles where `ms_tick` is 1. A warning with no ticks never leads to a cut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| warn_n | input | 1 | Thermal warning from output stage, active low, asynchronous |
| adj_bypass | input | 1 | 1 = attenuation feature disabled |
| rec_bypass | input | 1 | 1 = latch the cut after the warning clears |
| post_scale | input | ATT_W | Attenuation magnitude, 0.5 dB per step |
| atten_active | output | 1 | Cut currently requested |
| atten_level | output | ATT_W | Attenuation to apply, 0 when inactive |

## Verification
A change on `warn_n` reaches the controller two edges later. The state moves one edge after that. The timer then needs QUAL_MS+1 ticks plus one edge before the cut appears, which makes edge 405 from the fall with default parameters. A change of `adj_bypass` or `rec_bypass` acts at the next edge. `atten_level` follows `atten_active` with no register in between. The bench drives inputs on the falling clock edge and waits a stated number of rising edges. It samples on a falling edge, so every check lands in a cycle where the output has settled. The exact-boundary test samples once after edge 404 and once after edge 405. The vector table uses waits long enough to clear these latencies.

// File: rtl/tgl_pkg.sv
package tgl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_QUALIFY = 2'd1,
        ST_ATTEN   = 2'd2,
        ST_HOLD    = 2'd3
    } tgl_state_e;

    function automatic int unsigned tgl_cnt_width(input int unsigned qual_ms);
        return $clog2(qual_ms + 2);
    endfunction

endpackage

// File: rtl/tgl_sync2.sv
module tgl_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic stage1;
    logic stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/tgl_qual_timer.sv
module tgl_qual_timer #(
    parameter int unsigned QUAL_MS = 400,
    localparam int unsigned CW     = tgl_pkg::tgl_cnt_width(QUAL_MS),
    localparam int unsigned LIMIT  = QUAL_MS + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic          expired
);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

    assign expired = (cnt == LIMIT_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tgl_ctrl_fsm.sv
module tgl_ctrl_fsm
    import tgl_pkg::*;
#(
    parameter int unsigned ATT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warn_s,
    input  logic             adj_bypass,
    input  logic             rec_bypass,
    input  logic             tmr_expired,
    input  logic [ATT_W-1:0] post_scale,
    output tgl_state_e       state,
    output logic             tmr_run,
    output logic             atten_on,
    output logic [ATT_W-1:0] atten_level
);
    tgl_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (warn_s && !adj_bypass) state_nx = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (adj_bypass || !warn_s) state_nx = ST_IDLE;
                else if (tmr_expired)      state_nx = ST_ATTEN;
            end
            ST_ATTEN: begin
                if (adj_bypass)      state_nx = ST_IDLE;
                else if (!warn_s)    state_nx = rec_bypass ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (adj_bypass || !rec_bypass) state_nx = ST_IDLE;
                else if (warn_s)               state_nx = ST_ATTEN;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_run     = 1'b0;
        atten_on    = 1'b0;
        atten_level = '0;
        unique case (state)
            ST_IDLE:    ;
            ST_QUALIFY: tmr_run = 1'b1;
            ST_ATTEN,
            ST_HOLD: begin
                atten_on    = 1'b1;
                atten_level = post_scale;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/thermal_gain_limiter.sv
module thermal_gain_limiter
    import tgl_pkg::*;
#(
    parameter int unsigned QUAL_MS = 400,
    parameter int unsigned ATT_W   = 8,
    localparam int unsigned CW     = tgl_cnt_width(QUAL_MS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             warn_n,
    input  logic             adj_bypass,
    input  logic             rec_bypass,
    input  logic [ATT_W-1:0] post_scale,
    output logic             atten_active,
    output logic [ATT_W-1:0] atten_level
);
    logic          warn_n_s;
    logic          warn_s;
    logic          tmr_run;
    logic          tmr_expired;
    logic [CW-1:0] tmr_cnt;
    tgl_state_e    state;

    tgl_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (warn_n),
        .q_sync  (warn_n_s)
    );

    assign warn_s = ~warn_n_s;

    tgl_qual_timer #(.QUAL_MS(QUAL_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .tick    (ms_tick),
        .cnt     (tmr_cnt),
        .expired (tmr_expired)
    );

    tgl_ctrl_fsm #(.ATT_W(ATT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .warn_s      (warn_s),
        .adj_bypass  (adj_bypass),
        .rec_bypass  (rec_bypass),
        .tmr_expired (tmr_expired),
        .post_scale  (post_scale),
        .state       (state),
        .tmr_run     (tmr_run),
        .atten_on    (atten_active),
        .atten_level (atten_level)
    );
endmodule

// File: rtl/thermal_gain_limiter_chk.sv
module thermal_gain_limiter_chk
    import tgl_pkg::*;
#(
    parameter int unsigned QUAL_MS = 400,
    localparam int unsigned CW     = tgl_cnt_width(QUAL_MS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adj_bypass,
    input logic          rec_bypass,
    input logic          warn_s,
    input logic          tmr_expired,
    input logic [CW-1:0] tmr_cnt,
    input tgl_state_e    state,
    input logic          atten_active
);
    localparam logic [CW-1:0] LIMIT_V = CW'(QUAL_MS + 1);

    // R2: a new cut only follows an expired qualification window
    assert_rise_after_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(atten_active) |-> $past(tmr_expired));

    // R2: the timer never runs past its limit
    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_cnt <= LIMIT_V);

    // R3: outside qualification the count is cleared
    assert_cnt_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_QUALIFY) |=> (tmr_cnt == '0));

    // R4: bypass removes or blocks the cut
    assert_bypass_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adj_bypass |=> !atten_active);

    // R5: auto recovery drops the cut when the warning is gone
    assert_auto_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (atten_active && !rec_bypass && !warn_s) |=> !atten_active);

    // R6: latching keeps the cut while enabled
    assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (atten_active && rec_bypass && !adj_bypass) |=> atten_active);
endmodule

bind thermal_gain_limiter thermal_gain_limiter_chk #(.QUAL_MS(QUAL_MS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .adj_bypass   (adj_bypass),
    .rec_bypass   (rec_bypass),
    .warn_s       (warn_s),
    .tmr_expired  (tmr_expired),
    .tmr_cnt      (tmr_cnt),
    .state        (state),
    .atten_active (atten_active)
);

// File: tb/thermal_gain_limiter_tb_top.sv
module thermal_gain_limiter_tb_top;
    localparam int unsigned ATT_W = 8;
    localparam int unsigned NVEC  = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ms_tick = 1'b1;
    logic             warn_n = 1'b1;
    logic             adj_bypass = 1'b1;
    logic             rec_bypass = 1'b1;
    logic [ATT_W-1:0] post_scale = 8'd6;
    logic             atten_active;
    logic [ATT_W-1:0] atten_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    thermal_gain_limiter #(.QUAL_MS(400), .ATT_W(ATT_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .warn_n       (warn_n),
        .adj_bypass   (adj_bypass),
        .rec_bypass   (rec_bypass),
        .post_scale   (post_scale),
        .atten_active (atten_active),
        .atten_level  (atten_level)
    );

    // fields: [23:20] req, [19] warn_n, [18] adj_bypass, [17] rec_bypass,
    //         [16] expected active, [15:0] wait in cycles
    localparam logic [23:0] VEC [NVEC] = '{
        {4'd4, 1'b0, 1'b1, 1'b1, 1'b0, 16'd500},  // R4 bypass blocks
        {4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 16'd10},   // R3 idle
        {4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'd300},  // R2 not yet qualified
        {4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 16'd5},    // R3 abort
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'd300},  // R3 restarted count
        {4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 16'd200},  // R2 qualified
        {4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 16'd5},    // R5 auto recovery
        {4'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'd420},  // R2 qualified, latching
        {4'd6, 1'b1, 1'b0, 1'b1, 1'b1, 16'd50},   // R6 latched
        {4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 16'd3},    // R7 release
        {4'd6, 1'b0, 1'b0, 1'b1, 1'b1, 16'd420},  // R6 applied again
        {4'd4, 1'b0, 1'b1, 1'b1, 1'b0, 16'd3}     // R4 bypass removes
    };

    task automatic check(input bit ok, input int req, input int act, input int exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_out(input int req, input bit exp_on, input string what);
        int exp_lvl;
        exp_lvl = exp_on ? int'(post_scale) : 0;
        check(atten_active == exp_on, req, int'(atten_active), int'(exp_on), {what, " active"});
        check(int'(atten_level) == exp_lvl, 8, int'(atten_level), exp_lvl, {what, " level"});
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out(9, 1'b0, "R9 in reset");
        rst_n = 1'b1;
        cycles(2);
        check_out(9, 1'b0, "R9 after reset");

        for (int i = 0; i < NVEC; i++) begin
            warn_n     = VEC[i][19];
            adj_bypass = VEC[i][18];
            rec_bypass = VEC[i][17];
            cycles(int'(VEC[i][15:0]));
            check_out(int'(VEC[i][23:20]), VEC[i][16], $sformatf("vector %0d", i));
        end

        // R1/R2 exact boundary: rise after edge 405
        warn_n = 1'b1; adj_bypass = 1'b0; rec_bypass = 1'b0;
        cycles(5);
        warn_n = 1'b0;
        cycles(404);
        check_out(1, 1'b0, "R1 edge 404");
        cycles(1);
        check_out(1, 1'b1, "R1 edge 405");

        // R8 level follows post_scale
        post_scale = 8'd9;
        #1;
        check_out(8, 1'b1, "R8 new scale");
        post_scale = 8'd6;

        // R5 exact release edge: third edge after rise
        warn_n = 1'b1;
        cycles(2);
        check_out(5, 1'b1, "R5 edge 2");
        cycles(1);
        check_out(5, 1'b0, "R5 edge 3");

        // R10 no ticks, no progress
        ms_tick = 1'b0;
        warn_n  = 1'b0;
        cycles(1000);
        check_out(10, 1'b0, "R10 no ticks");
        ms_tick = 1'b1;
        cycles(410);
        check_out(10, 1'b1, "R10 ticks resume");

        // R9 reset clears a latched cut
        rec_bypass = 1'b1;
        warn_n = 1'b1;
        cycles(10);
        check_out(6, 1'b1, "R6 latched before reset");
        rst_n = 1'b0;
        cycles(2);
        check_out(9, 1'b0, "R9 reset during hold");
        rst_n = 1'b1;
        cycles(5);
        check_out(9, 1'b0, "R9 stays clear");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule